// File: doc/BRIEF.md
# Video DMA Bus Takeover Handshake

This block gives the video fetch sequencer the processor's half of the shared memory bus when it needs it. Each bus cycle has two halves. The first half always belongs to the video side. The second half belongs to the processor unless the sequencer has claimed it for a screen-code fetch on a character-row start line or for a sprite data fetch. The sequencer raises a request one cycle ahead for each cycle it will claim. The block then pulls the bus-available line low as a warning and withholds the processor's address enable in the claimed cycles. It releases both once the claims are over.

During the warning lead, the processor may go on writing. It is halted at its first read and held until the bus is handed back. A per-line counter records how many processor halves were taken, so the number can be compared with the number of active sprites and the row-start flag. The block runs on a half-cycle clock, and one register of its own tracks which half is current.

Top module: `bus_steal_ctrl`

## Requirements
- R1: After reset, bus_avail and cpu_ready are 1, cpu_addr_en is 0, steal_count is 0, and cpu_half is 0 (video half).
- R2: cpu_addr_en is 0 in every video half (cpu_half = 0). It is 1 in the processor half (cpu_half = 1) of every cycle that is not stolen.
- R3: A steal_req held during bus cycle n drives bus_avail to 0 from cycle n+1. It makes cycle n+4 a stolen cycle, with cpu_addr_en at 0 in both halves, so the warning lasts exactly 3 cycles.
- R4: When no request is pending, bus_avail returns to 1 in the cycle that follows the last stolen cycle. cpu_addr_en returns to 1 in that cycle's processor half.
- R5: If the requests are separated by fewer than 4 cycles, the resulting warning and stolen cycles form one unbroken interval with bus_avail at 0.
- R6: A request made in the first cycle after bus_avail has risen again drops bus_avail at once, in the next cycle. The stolen cycle still comes only after the full 3-cycle lead.
- R7: cpu_ready equals bus_avail in every cycle.
- R8: cpu_rd = 1 means a read and cpu_rd = 0 means a write. While bus_avail is 0 in a cycle that is not stolen, a write does not raise cpu_stall, but a read does. Once a read has stalled, cpu_stall stays at 1 until bus_avail returns to 1.
- R9: cpu_stall is 1 in every stolen cycle, whatever the value of cpu_rd.
- R10: At the end of a cycle with line_start = 1, steal_count is loaded with 1 if that cycle was stolen and with 0 otherwise. Every other stolen cycle adds one. The count saturates at 2^CNT_W-1 (127 by default).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-cycle clock; two edges make one bus cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| steal_req | input | 1 | This cycle's processor half will be claimed 4 cycles from now |
| line_start | input | 1 | This cycle is the first cycle of a raster line |
| cpu_rd | input | 1 | Processor access this cycle is a read (1) or write (0) |
| bus_avail | output | 1 | 0 while a takeover is announced or in progress |
| cpu_ready | output | 1 | Processor ready, equal to bus_avail |
| cpu_addr_en | output | 1 | Processor owns the address bus in this half |
| cpu_stall | output | 1 | Processor must hold its current access this cycle |
| cpu_half | output | 1 | 0 for video half, 1 for processor half |
| steal_count | output | CNT_W | Stolen processor cycles since the last line start |

## Verification
A request moves through a pipeline that advances once per bus cycle. bus_avail therefore responds one full cycle after a request, and the stolen processor half comes four cycles after it. cpu_stall follows cpu_rd within the same processor half. steal_count changes at the edge that ends a cycle. Each bench step applies its inputs at the start of the video half. It checks cpu_addr_en in that half, checks bus_avail, cpu_ready, cpu_addr_en and cpu_stall in the processor half, and checks steal_count after the closing edge. A reference model keeps the last four requests and predicts each of these values in the cycle where it is due.

// File: rtl/bus_steal_pkg.sv
// Shared definitions for the bus takeover handshake.
// Assumes: one bus cycle is two clock edges, video half first.
package bus_steal_pkg;
    typedef enum logic {
        HALF_VIDEO = 1'b0,
        HALF_CPU   = 1'b1
    } half_e;

    localparam int DEFAULT_LEAD  = 3;
    localparam int DEFAULT_CNT_W = 7;
endpackage

// File: rtl/bst_phase.sv
// Half-cycle tracker: tells which half of the bus cycle is current and
// flags the edge that closes a bus cycle.
// Assumes: reset leaves the block in the video half.
module bst_phase
    import bus_steal_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    output half_e half_o,
    output logic  cycle_end_o
);
    half_e half_q;

    // Alternate halves on every edge; reset lands in the video half.
    always_ff @(posedge clk) begin
        if (!rst_n) half_q <= HALF_VIDEO;
        else        half_q <= (half_q == HALF_VIDEO) ? HALF_CPU : HALF_VIDEO;
    end

    assign half_o      = half_q;
    assign cycle_end_o = (half_q == HALF_CPU);

    assert_half_alternates_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_end_o |=> (half_o == HALF_VIDEO));
endmodule

// File: rtl/bst_lead_pipe.sv
// Request lead pipeline: each request enters once per bus cycle and comes
// out LEAD+1 cycles later as a stolen cycle. Any bit still in flight keeps
// the warning line asserted, so adjacent requests merge.
// Assumes: shift_en pulses once per bus cycle.
module bst_lead_pipe #(
    parameter int LEAD = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic shift_en,
    input  logic req_i,
    output logic warn_o,
    output logic stolen_o
);
    localparam int DEPTH = LEAD + 1;

    logic [DEPTH-1:0] stage_q;

    // Shift requests toward the stolen slot once per bus cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)        stage_q <= '0;
        else if (shift_en) stage_q <= {stage_q[DEPTH-2:0], req_i};
    end

    assign warn_o   = |stage_q;
    assign stolen_o = stage_q[DEPTH-1];

    assert_req_warns_next_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && req_i) |=> warn_o);
    assert_steal_under_warn_R3: assert property (@(posedge clk) disable iff (!rst_n)
        stolen_o |-> warn_o);
    assert_release_after_steal_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(warn_o) |-> $past(stolen_o));
    assert_stolen_holds_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(stolen_o));
endmodule

// File: rtl/bst_cpu_gate.sv
// Processor hold logic: writes may proceed during the warning, the first
// read freezes the processor, and the freeze lasts until the bus is free.
// Assumes: cpu_rd is steady through both halves of a cycle.
module bst_cpu_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic cycle_end,
    input  logic warn,
    input  logic stolen,
    input  logic cpu_rd,
    output logic stall_o
);
    logic frozen_q;

    // Remember a read that hit the warning window; forget it once the bus is free.
    always_ff @(posedge clk) begin
        if (!rst_n)              frozen_q <= 1'b0;
        else if (cycle_end) begin
            if (!warn)           frozen_q <= 1'b0;
            else if (cpu_rd)     frozen_q <= 1'b1;
        end
    end

    // Hold the processor on a stolen cycle, a read, or a standing freeze.
    always_comb begin
        stall_o = warn && (stolen || cpu_rd || frozen_q);
    end

    assert_freeze_sticks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (frozen_q && warn) |-> stall_o);
    assert_free_bus_no_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !warn |-> !stall_o);
endmodule

// File: rtl/bst_steal_count.sv
// Per-line stolen cycle counter with saturation.
// Assumes: line_start is held through the first bus cycle of a line.
module bst_steal_count #(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cycle_end,
    input  logic             line_start,
    input  logic             stolen,
    output logic [CNT_W-1:0] count_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;

    // Restart on a line start, otherwise add stolen cycles up to the ceiling.
    always_ff @(posedge clk) begin
        if (!rst_n)                       cnt_q <= '0;
        else if (cycle_end) begin
            if (line_start)               cnt_q <= stolen ? CNT_W'(1) : '0;
            else if (stolen && cnt_q != CNT_MAX)
                                          cnt_q <= cnt_q + 1'b1;
        end
    end

    assign count_o = cnt_q;

    assert_line_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cycle_end && line_start && !stolen) |=> (count_o == '0));
    assert_saturates_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cycle_end && !line_start && count_o == CNT_MAX) |=> (count_o == CNT_MAX));
    assert_idle_keeps_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!line_start && !stolen) |=> $stable(count_o));
endmodule

// File: rtl/bus_steal_ctrl.sv
// Bus takeover handshake for the video fetch sequencer. It announces each
// claim LEAD cycles ahead on bus_avail, withholds the processor address
// enable in claimed cycles, stalls the processor on its first read during
// the warning, and counts stolen cycles per line.
// Assumes: steal_req, line_start and cpu_rd change only at cycle start.
module bus_steal_ctrl
    import bus_steal_pkg::*;
#(
    parameter int LEAD  = DEFAULT_LEAD,
    parameter int CNT_W = DEFAULT_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             steal_req,
    input  logic             line_start,
    input  logic             cpu_rd,
    output logic             bus_avail,
    output logic             cpu_ready,
    output logic             cpu_addr_en,
    output logic             cpu_stall,
    output logic             cpu_half,
    output logic [CNT_W-1:0] steal_count
);
    half_e half;
    logic  cycle_end;
    logic  warn;
    logic  stolen;

    bst_phase u_phase (
        .clk         (clk),
        .rst_n       (rst_n),
        .half_o      (half),
        .cycle_end_o (cycle_end)
    );

    bst_lead_pipe #(.LEAD(LEAD)) u_pipe (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (cycle_end),
        .req_i    (steal_req),
        .warn_o   (warn),
        .stolen_o (stolen)
    );

    bst_cpu_gate u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .cycle_end (cycle_end),
        .warn      (warn),
        .stolen    (stolen),
        .cpu_rd    (cpu_rd),
        .stall_o   (cpu_stall)
    );

    bst_steal_count #(.CNT_W(CNT_W)) u_count (
        .clk        (clk),
        .rst_n      (rst_n),
        .cycle_end  (cycle_end),
        .line_start (line_start),
        .stolen     (stolen),
        .count_o    (steal_count)
    );

    // Drive the handshake pins: processor owns only its own unclaimed half.
    always_comb begin
        bus_avail   = !warn;
        cpu_ready   = !warn;
        cpu_addr_en = (half == HALF_CPU) && !stolen;
        cpu_half    = (half == HALF_CPU);
    end

    assert_video_half_owned_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_half |-> !cpu_addr_en);
    assert_stolen_stalls_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_half && !cpu_addr_en) |-> cpu_stall);
    assert_ready_tracks_ba_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_avail) |-> cpu_ready);
endmodule

// File: tb/bus_steal_ctrl_tb.sv
`timescale 1ns/1ps
module bus_steal_ctrl_tb;
    localparam int LEAD  = 3;
    localparam int CNT_W = 7;
    localparam int CMAX  = (1 << CNT_W) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic steal_req = 1'b0, line_start = 1'b0, cpu_rd = 1'b0;
    logic bus_avail, cpu_ready, cpu_addr_en, cpu_stall, cpu_half;
    logic [CNT_W-1:0] steal_count;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    // reference model state
    logic [LEAD:0] m_hist = '0;
    logic          m_frozen = 1'b0;
    int            m_cnt = 0;

    // last samples from the processor half
    logic s_ba, s_aec, s_stall;

    always #2.5 clk = ~clk;

    bus_steal_ctrl #(.LEAD(LEAD), .CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .steal_req(steal_req), .line_start(line_start),
        .cpu_rd(cpu_rd), .bus_avail(bus_avail), .cpu_ready(cpu_ready),
        .cpu_addr_en(cpu_addr_en), .cpu_stall(cpu_stall), .cpu_half(cpu_half),
        .steal_count(steal_count)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One bus cycle: inputs at video-half start, checks in each half.
    task automatic step(input logic req, input logic rd, input logic ls);
        logic e_warn, e_stolen, e_stall;
        steal_req = req; cpu_rd = rd; line_start = ls;
        e_warn   = |m_hist;
        e_stolen = m_hist[LEAD];
        e_stall  = e_warn && (e_stolen || rd || m_frozen);
        chk(cpu_half == 1'b0, "R2 half", cpu_half, 0);
        chk(cpu_addr_en == 1'b0, "R2 video-half aec", cpu_addr_en, 0);
        @(posedge clk); @(negedge clk);
        s_ba = bus_avail; s_aec = cpu_addr_en; s_stall = cpu_stall;
        chk(bus_avail == !e_warn, "R3/R5 bus_avail", bus_avail, !e_warn);
        chk(cpu_ready == bus_avail, "R7 ready", cpu_ready, bus_avail);
        chk(cpu_addr_en == !e_stolen, "R2 cpu-half aec", cpu_addr_en, !e_stolen);
        chk(cpu_stall == e_stall, "R8 stall", cpu_stall, e_stall);
        @(posedge clk); @(negedge clk);
        if (ls) m_cnt = e_stolen ? 1 : 0;
        else if (e_stolen && m_cnt < CMAX) m_cnt++;
        m_frozen = e_warn ? (m_frozen | rd) : 1'b0;
        m_hist   = {m_hist[LEAD-1:0], req};
        chk(int'(steal_count) == m_cnt, "R10 count", steal_count, m_cnt);
    endtask

    task automatic t_reset();
        chk(bus_avail == 1'b1, "R1 bus_avail", bus_avail, 1);
        chk(cpu_ready == 1'b1, "R1 ready", cpu_ready, 1);
        chk(cpu_addr_en == 1'b0, "R1 aec", cpu_addr_en, 0);
        chk(steal_count == '0, "R1 count", steal_count, 0);
        chk(cpu_half == 1'b0, "R1 half", cpu_half, 0);
    endtask

    task automatic t_single();
        step(1, 0, 0);
        chk(s_ba == 1'b1, "R3 no warn in request cycle", s_ba, 1);
        for (int k = 1; k <= 6; k++) begin
            step(0, 0, 0);
            if (k == 1) chk(s_ba == 1'b0, "R3 warn next cycle", s_ba, 0);
            if (k == 3) chk(s_aec == 1'b1, "R3 not stolen early", s_aec, 1);
            if (k == 4) begin
                chk(s_aec == 1'b0, "R3 stolen at lead", s_aec, 0);
                chk(s_stall == 1'b1, "R9 stolen stalls write", s_stall, 1);
            end
            if (k == 5) begin
                chk(s_ba == 1'b1, "R4 release", s_ba, 1);
                chk(s_aec == 1'b1, "R4 aec resumes", s_aec, 1);
            end
        end
    endtask

    task automatic t_merge();
        bit gap = 1'b0;
        for (int k = 0; k < 8; k++) step(1, 0, 0);
        step(0, 0, 0);
        for (int k = 0; k < 2; k++) step(1, 0, 0);
        for (int k = 0; k < 4; k++) begin
            step(0, 0, 0);
            if (s_ba) gap = 1'b1;
        end
        chk(gap == 1'b0, "R5 merged interval", gap, 0);
        step(0, 0, 0);
        chk(s_ba == 1'b1, "R4 release after merge", s_ba, 1);
        for (int k = 0; k < 3; k++) step(0, 0, 0);
    endtask

    task automatic t_rearm();
        step(1, 0, 0);
        for (int k = 0; k < 4; k++) step(0, 0, 0);
        step(1, 0, 0);
        chk(s_ba == 1'b1, "R6 high before rearm", s_ba, 1);
        step(0, 0, 0);
        chk(s_ba == 1'b0, "R6 lowered at once", s_ba, 0);
        step(0, 0, 0);
        step(0, 0, 0);
        chk(s_aec == 1'b1, "R6 no early theft", s_aec, 1);
        step(0, 0, 0);
        chk(s_aec == 1'b0, "R6 theft after full lead", s_aec, 0);
        for (int k = 0; k < 3; k++) step(0, 0, 0);
    endtask

    task automatic t_freeze();
        step(1, 0, 0);
        step(0, 0, 0);
        chk(s_stall == 1'b0, "R8 write passes in warning", s_stall, 0);
        step(0, 1, 0);
        chk(s_stall == 1'b1, "R8 read stalls", s_stall, 1);
        step(0, 0, 0);
        chk(s_stall == 1'b1, "R8 freeze holds", s_stall, 1);
        step(0, 1, 0);
        chk(s_stall == 1'b1, "R9 stolen stall", s_stall, 1);
        step(0, 1, 0);
        chk(s_stall == 1'b0, "R8 freed after release", s_stall, 0);
        for (int k = 0; k < 2; k++) step(0, 0, 0);
    endtask

    task automatic t_count();
        step(0, 0, 1);
        for (int k = 1; k < 30; k++)
            step((k == 1 || k == 2 || k == 10 || k == 20 || k == 21 || k == 22), 0, 0);
        chk(int'(steal_count) == 6, "R10 six stolen", steal_count, 6);
        step(0, 0, 1);
        chk(steal_count == '0, "R10 line clears", steal_count, 0);
    endtask

    task automatic t_saturate();
        step(0, 0, 1);
        for (int k = 0; k < 135; k++) step(1, 0, 0);
        for (int k = 0; k < 6; k++) step(0, 0, 0);
        chk(int'(steal_count) == CMAX, "R10 saturation", steal_count, CMAX);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_single();
        t_merge();
        t_rearm();
        t_freeze();
        t_count();
        t_saturate();
        finish_run();
    end

    initial begin
        #(200000 * 5.0);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_run();
    end
endmodule